// File: doc/BRIEF.md
# Privilege-Gated Auxiliary Control Register

This block holds one 32-bit word of implementation-specific control bits. Software reaches the word through a coprocessor-style port. Each access carries three things: a two-bit privilege level, a flag that marks the access as coming from the non-secure world, and a read/write select. The block decides, bit by bit, whether a write may land. It also returns read data one cycle after each read, and raises a one-cycle fault when unprivileged code touches the register. The word is not banked, so both security worlds see the same storage.

Next to the stored word the block drives an effective control vector for the downstream pipeline, cache and predictor logic. In that vector a few "stronger" bits force a companion bit on. Setting bit 12 forces bit 13 on, and setting bit 10 forces bit 11 on. Reads always return the stored word, not the forced one. An external delegation input lets a secure supervisor open one bit, bit 6, to non-secure software.

Top module: `aux_ctl_reg`

## Requirements
- R1: After reset the stored word and the effective vector are all zero, and `rd_valid` and `undef_fault` are low.
- R2: A write from privilege 1, 2 or 3 with `acc_nonsec` low stores all 32 bits of `acc_wdata`. A read returns the stored word on `rd_data` one cycle after the access.
- R3: A write with `acc_nonsec` high, privilege 1 to 3 and `ns_deleg` low changes no bit. A read under the same conditions still returns the stored word.
- R4: A write with `acc_nonsec` high, privilege 1 to 3 and `ns_deleg` high updates bit 6 only. Every other bit keeps its value.
- R5: An access at privilege 0 (encoding 2'b00) pulses `undef_fault` high for exactly the cycle after the access. A privilege-0 write changes nothing. A privilege-0 read returns zero with `rd_valid` high.
- R6: When stored bit 12 is 1, `eff_ctl[13]` is 1, whatever stored bit 13 holds.
- R7: When stored bit 10 is 1, `eff_ctl[11]` is 1, whatever stored bit 11 holds.
- R8: Every other bit of `eff_ctl` equals the stored bit. `rd_data` always carries the stored bits, not the forced ones.
- R9: `rd_valid` is high exactly in the cycle after a read access and low at all other times. `undef_fault` is low except after a privilege-0 access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 2 | Privilege level, 0 = unprivileged |
| acc_nonsec | input | 1 | Access comes from the non-secure world |
| ns_deleg | input | 1 | Opens bit 6 to non-secure writes |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response, one cycle after the access |
| undef_fault | output | 1 | One-cycle fault for a privilege-0 access |
| eff_ctl | output | 32 | Effective controls with forcing applied |

## Verification
The bench writes all-ones words from each corner of the privilege, security and delegation space:
- Secure writes show whether the full word lands.
- Non-secure writes with delegation off show whether the write gate leaks.
- Non-secure writes with delegation on show that bit 6 alone moves.
- Privilege-0 writes show that the fault path also blocks the write.

Words that set only a forcing bit (bit 12 or bit 10) tell the effective vector apart from the stored value returned on reads. After these directed cases, random mixes of all fields run against a reference model, which covers combinations of forcing bits and delegation changes that the directed cases do not reach.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_KERN = 2'd1,
      PRIV_HYP  = 2'd2,
      PRIV_MON  = 2'd3
   } priv_e;

   typedef struct packed {
      logic wr_en;
      logic rd_en;
      logic fault;
   } acc_dec_t;

endpackage

// File: rtl/aux_ctl_access.sv
module aux_ctl_access
   import aux_ctl_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned DELEG_BIT  = 6,
   parameter bit          NS_DELEG_ON = 1'b1
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_priv,
   input  logic              acc_nonsec,
   input  logic              ns_deleg,
   output acc_dec_t          dec,
   output logic [DATA_W-1:0] wr_mask
);

   localparam logic [DATA_W-1:0] ONE_HOT_DELEG = {{(DATA_W-1){1'b0}}, 1'b1} << DELEG_BIT;
   localparam logic [DATA_W-1:0] ALL_ONES      = {DATA_W{1'b1}};

   logic              is_user;
   logic [DATA_W-1:0] ns_mask;

   assign is_user = (priv_e'(acc_priv) == PRIV_USER);

   generate
      if (NS_DELEG_ON) begin : g_deleg
         assign ns_mask = ns_deleg ? ONE_HOT_DELEG : '0;
      end else begin : g_locked
         assign ns_mask = '0;
      end
   endgenerate

   always_comb begin
      dec.fault = acc_valid && is_user;
      dec.wr_en = acc_valid && acc_write && !is_user;
      dec.rd_en = acc_valid && !acc_write;
      if (!acc_nonsec) wr_mask = ALL_ONES;
      else             wr_mask = ns_mask;
   end

endmodule

// File: rtl/aux_ctl_store.sv
module aux_ctl_store #(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] stored
);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     stored[i] <= RST_VAL[i];
            else if (wr_en && wr_mask[i])   stored[i] <= wr_data[i];
         end
      end
   endgenerate

endmodule

// File: rtl/aux_ctl_force.sv
module aux_ctl_force #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned N_FORCE = 2,
   parameter logic [N_FORCE*8-1:0] SRC_IDX = {8'd12, 8'd10},
   parameter logic [N_FORCE*8-1:0] DST_IDX = {8'd13, 8'd11}
) (
   input  logic [DATA_W-1:0] stored,
   output logic [DATA_W-1:0] eff
);

   logic [DATA_W-1:0] force_vec [N_FORCE];

   generate
      for (genvar k = 0; k < N_FORCE; k++) begin : g_pair
         localparam int unsigned S = int'(SRC_IDX[k*8 +: 8]);
         localparam int unsigned D = int'(DST_IDX[k*8 +: 8]);
         if (S >= DATA_W || D >= DATA_W) begin : g_bad
            $error("force pair index outside the word");
         end
         assign force_vec[k] = stored[S] ? ({{(DATA_W-1){1'b0}}, 1'b1} << D) : '0;
      end
   endgenerate

   always_comb begin
      eff = stored;
      for (int k = 0; k < N_FORCE; k++) eff = eff | force_vec[k];
   end

endmodule

// File: rtl/aux_ctl_reg.sv
module aux_ctl_reg
   import aux_ctl_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DELEG_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [1:0]        acc_priv,
   input  logic              acc_nonsec,
   input  logic              ns_deleg,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              undef_fault,
   output logic [DATA_W-1:0] eff_ctl
);

   localparam logic [DATA_W-1:0] DELEG_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << DELEG_BIT;

   generate
      if (DELEG_BIT >= DATA_W) begin : g_bad_deleg
         $error("delegated bit outside the word");
      end
      if (DATA_W < 14) begin : g_bad_width
         $error("word too narrow for the forcing pairs");
      end
   endgenerate

   acc_dec_t          dec;
   logic [DATA_W-1:0] wr_mask;
   logic [DATA_W-1:0] stored;

   aux_ctl_access #(.DATA_W(DATA_W), .DELEG_BIT(DELEG_BIT), .NS_DELEG_ON(1'b1)) u_access (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_priv  (acc_priv),
      .acc_nonsec(acc_nonsec),
      .ns_deleg  (ns_deleg),
      .dec       (dec),
      .wr_mask   (wr_mask)
   );

   aux_ctl_store #(.DATA_W(DATA_W), .RST_VAL('0)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (dec.wr_en),
      .wr_mask(wr_mask),
      .wr_data(acc_wdata),
      .stored (stored)
   );

   aux_ctl_force #(.DATA_W(DATA_W), .N_FORCE(2),
                   .SRC_IDX({8'd12, 8'd10}), .DST_IDX({8'd13, 8'd11})) u_force (
      .stored(stored),
      .eff   (eff_ctl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data     <= '0;
         rd_valid    <= 1'b0;
         undef_fault <= 1'b0;
      end else begin
         rd_valid    <= dec.rd_en;
         undef_fault <= dec.fault;
         if (dec.rd_en) rd_data <= dec.fault ? '0 : stored;
      end
   end

   AST_NS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_nonsec && !ns_deleg) |=> $stable(stored)); // R3
   AST_NS_DELEG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_nonsec && ns_deleg) |=> (((stored ^ $past(stored)) & ~DELEG_MASK) == '0)); // R4
   AST_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_priv == 2'd0) |=> undef_fault); // R5
   AST_USER_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_priv == 2'd0) |=> $stable(stored)); // R5
   AST_USER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && acc_priv == 2'd0) |=> (rd_data == '0)); // R5
   AST_RD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |=> rd_valid); // R9
   AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !acc_write) |=> !rd_valid); // R9

endmodule

// File: tb/aux_ctl_reg_test.sv
module aux_ctl_reg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [1:0]  acc_priv = 2'd0;
   logic        acc_nonsec = 1'b0;
   logic        ns_deleg = 1'b0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        undef_fault;
   logic [31:0] eff_ctl;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [31:0] model = '0;

   always #5 clk = ~clk;

   aux_ctl_reg uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_wdata(acc_wdata), .acc_priv(acc_priv), .acc_nonsec(acc_nonsec),
      .ns_deleg(ns_deleg), .rd_data(rd_data), .rd_valid(rd_valid),
      .undef_fault(undef_fault), .eff_ctl(eff_ctl)
   );

   function automatic logic [31:0] next_word(logic [31:0] old, logic [31:0] d,
                                             logic [1:0] p, bit ns, bit dg);
      if (p == 2'd0) return old;
      if (!ns) return d;
      if (dg) return (old & ~32'h40) | (d & 32'h40);
      return old;
   endfunction

   function automatic logic [31:0] eff_of(logic [31:0] s);
      logic [31:0] e = s;
      if (s[12]) e[13] = 1'b1;
      if (s[10]) e[11] = 1'b1;
      return e;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_acc(input bit w, input logic [31:0] d, input logic [1:0] p,
                         input bit ns, input bit dg);
      logic [31:0] pre = model;
      acc_valid = 1'b1; acc_write = w; acc_wdata = d;
      acc_priv = p; acc_nonsec = ns; ns_deleg = dg;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      if (w) model = next_word(model, d, p, ns, dg);
      chk({31'd0, undef_fault}, {31'd0, p == 2'd0}, "R5 fault");
      chk({31'd0, rd_valid}, {31'd0, !w}, "R9 rd_valid");
      if (!w) chk(rd_data, (p == 2'd0) ? 32'd0 : pre,
                  (p == 2'd0) ? "R5 rd_data" : (ns ? "R3 rd_data" : "R2 rd_data"));
      chk(eff_ctl, eff_of(model), "R8 eff_ctl");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(eff_ctl, 32'd0, "R1 eff reset");
      chk({30'd0, rd_valid, undef_fault}, 32'd0, "R1 flags reset");
      do_acc(0, 0, 2'd1, 0, 0);
      chk(rd_data, 32'd0, "R1 stored reset");

      do_acc(1, 32'hFFFF_FFFF, 2'd1, 0, 0);
      do_acc(0, 0, 2'd3, 0, 0);
      chk(rd_data, 32'hFFFF_FFFF, "R2 full write");
      do_acc(1, 32'h0000_1000, 2'd2, 0, 0);
      chk(eff_ctl, 32'h0000_3000, "R6 force 13");
      do_acc(0, 0, 2'd1, 0, 0);
      chk(rd_data, 32'h0000_1000, "R8 read stored");
      do_acc(1, 32'h0000_0400, 2'd1, 0, 0);
      chk(eff_ctl, 32'h0000_0C00, "R7 force 11");
      do_acc(1, 32'h0000_0000, 2'd1, 0, 0);
      chk(eff_ctl, 32'h0, "R8 clear");

      do_acc(1, 32'hFFFF_FFFF, 2'd1, 1, 0);
      chk(eff_ctl, 32'h0, "R3 ns locked");
      do_acc(1, 32'hFFFF_FFFF, 2'd2, 1, 1);
      do_acc(0, 0, 2'd1, 0, 0);
      chk(rd_data, 32'h0000_0040, "R4 deleg bit only");

      do_acc(1, 32'h00FF_00FF, 2'd0, 0, 0);
      chk(eff_ctl, 32'h0000_0040, "R5 user write blocked");
      do_acc(0, 0, 2'd0, 0, 0);
      @(negedge clk);
      chk({30'd0, rd_valid, undef_fault}, 32'd0, "R9 idle");

      for (int i = 0; i < 400; i++) begin
         bit w = $urandom_range(0, 1) == 1;
         logic [1:0] p = 2'($urandom_range(0, 3));
         bit ns = $urandom_range(0, 1) == 1;
         bit dg = $urandom_range(0, 1) == 1;
         do_acc(w, $urandom, p, ns, dg);
         if ($urandom_range(0, 3) == 0) begin
            @(negedge clk);
            chk({30'd0, rd_valid, undef_fault}, 32'd0, "R9 idle gap");
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule